// File: doc/BRIEF.md
# Multi-Address Serial Bus Slave Matcher

This block watches the clock and data lines of a two-wire, open-drain (wired-AND) serial bus. It finds start and stop conditions and shifts in the first byte after each start. It then compares that byte against four programmable identity registers at the same time. Only the upper seven bits of each register take part in the comparison. The lowest bit of the received byte is the transfer direction.

When at least one register matches, the block does four things:
- It raises a one-cycle match pulse.
- It reports the number of the lowest matching register and the direction bit.
- It acknowledges by pulling the data line low for the ninth clock.
- It follows the bytes that come after, raising a strobe for each one together with its value.

When no register matches, the block goes dormant. It drives nothing and reports nothing until the bus shows the next start.

A host port writes the identity registers. A write is accepted only while the bus is free. A write that arrives during a transfer is dropped and answered with an error pulse.

Top module: `i2c_multi_id_matcher`

## Requirements
- R1: After reset the bus is seen as free: `busBusy`, `sdaPullLow`, `matchValid`, `byteRecvd` and `hostWrErr` are all 0, and every identity register holds 0x00.
- R2: A falling data line while the clock line is high is a start and sets `busBusy`. Both lines pass through two synchroniser flops first.
- R3: A register matches when its bits [7:1] equal bits [7:1] of the first byte after a start; bit 0 of the register is ignored.
- R4: On a match, `matchDir` shows bit 0 of the received address byte (1 = master reads, 0 = master writes).
- R5: When several registers match, `matchIdx` gives the lowest matching register number (register 0 is index 0, register 3 is index 3).
- R6: On a match, `sdaPullLow` is 1 from the clock fall after the eighth address bit until the clock fall after the ninth clock, so the line reads low while the ninth clock is high. The block never drives the data line high.
- R7: When no register matches, no acknowledge, no match pulse and no byte strobe appear until the next start; a repeated start evaluates a new address.
- R8: A host write while the bus is free loads `hostWrData` into the register chosen by `hostWrSel` (0 to 3), with no error.
- R9: A host write while the bus is busy leaves every register unchanged and gives a one-cycle `hostWrErr` pulse.
- R10: After a match, every eighth data clock gives a one-cycle `byteRecvd` pulse, with `rxByte` holding the byte (MSB first). The ninth clock of each byte is skipped.
- R11: A rising data line while the clock line is high is a stop: it clears `busBusy`, releases `sdaPullLow` and makes the bus free for host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sdaPullLow | output | 1 | 1 = pull the data line low (open-drain enable) |
| hostWrEn | input | 1 | Host write request, one cycle |
| hostWrSel | input | 2 | Identity register to write |
| hostWrData | input | 8 | Identity value to write |
| hostWrErr | output | 1 | Pulse: a write arrived while the bus was busy |
| busBusy | output | 1 | 1 between a start and a stop |
| matchValid | output | 1 | Pulse: the address byte matched a register |
| matchIdx | output | 2 | Lowest matching register number |
| matchDir | output | 1 | Direction bit of the matched address |
| byteRecvd | output | 1 | Pulse: a data byte was received |
| rxByte | output | 8 | Last data byte received |

## Verification
Each bus event reaches the control logic three clock edges after a line changes at the pins: two synchroniser flops, then one edge-history flop. The match pulse comes one edge later than that, because a compare state sits between the last shift and the result. `hostWrErr` follows a rejected write by one edge. The bench holds each bus phase for six clocks, so every level check (`busBusy`, the acknowledge seen on the wired-AND line while the ninth clock is high) is sampled well after its due edge. A monitor that samples on the falling edge counts the one-cycle pulses and latches the values that come with them, so no pulse is missed. Each scenario then compares those counts and latched values with the values worked out from the requirements.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMP,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_DATA,
    ST_DORMANT
  } matchState_t;

  // events decoded from the synchronised bus lines
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic sclFall;
    logic sclLevel;
  } busEvents_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic cmpEn;
    logic idWrEn;
  } ctlStrobes_t;

endpackage

// File: rtl/i2c_match_datapath.sv
module i2c_match_datapath
  import i2c_match_pkg::*;
#(
  parameter int NUM_IDS = 4,
  parameter int ID_W    = 8,
  localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrobes_t       strobes,
  input  logic              busyLevel,
  input  logic [IDX_W-1:0]  hostWrSel,
  input  logic [ID_W-1:0]   hostWrData,
  output busEvents_t        events,
  output logic              anyHit,
  output logic [IDX_W-1:0]  matchIdx,
  output logic              matchDir,
  output logic [ID_W-1:0]   rxByte
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic [ID_W-1:0] shiftReg;
  logic [ID_W-1:0] idRegs [NUM_IDS];
  logic [NUM_IDS-1:0] hitVec;
  logic [IDX_W-1:0] lowIdx;

  // two-flop synchronisers, idle bus level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_comb begin
    events.startDet = sclS && sclD && sdaD && !sdaS;
    events.stopDet  = sclS && sclD && !sdaD && sdaS;
    events.sclRise  = sclS && !sclD;
    events.sclFall  = !sclS && sclD;
    events.sclLevel = sclS;
  end

  // serial shift, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[ID_W-2:0], sdaS};
  end

  assign rxByte = shiftReg;

  // identity registers
  generate
    for (genvar gi = 0; gi < NUM_IDS; gi++) begin : gIdReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) idRegs[gi] <= '0;
        else if (strobes.idWrEn && (hostWrSel == IDX_W'(gi))) idRegs[gi] <= hostWrData;
      end
      assign hitVec[gi] = (idRegs[gi][ID_W-1:1] == shiftReg[ID_W-1:1]);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (hitVec[i]) lowIdx = IDX_W'(i);
    end
  end

  assign anyHit = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchIdx <= '0;
      matchDir <= 1'b0;
    end else if (strobes.cmpEn && anyHit) begin
      matchIdx <= lowIdx;
      matchDir <= shiftReg[0];
    end
  end

  // R9: identity registers hold while the bus is busy
  generate
    for (genvar ga = 0; ga < NUM_IDS; ga++) begin : gIdHold
      assert_id_stable_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
        busyLevel |=> $stable(idRegs[ga]));
    end
  endgenerate

  // R2/R11: start and stop never coincide
  assert_start_stop_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({events.startDet, events.stopDet}));

  // R5: reported index points to a register that matched the address
  assert_idx_hits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cmpEn && anyHit) |=> (idRegs[matchIdx][ID_W-1:1] == shiftReg[ID_W-1:1]));

endmodule

// File: rtl/i2c_match_control.sv
module i2c_match_control
  import i2c_match_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvents_t  events,
  input  logic        anyHit,
  input  logic        hostWrEn,
  output ctlStrobes_t strobes,
  output logic        sdaPullLow,
  output logic        hostWrErr,
  output logic        busBusy,
  output logic        matchValid,
  output logic        byteRecvd
);

  localparam int BITS_PER_BYTE = 8;
  localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);

  matchState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic ackDrive;
  logic busEdge;

  assign busEdge = events.startDet || events.stopDet;

  always_comb begin
    strobes.shiftEn = events.sclRise && !busEdge &&
                      ((state == ST_ADDR) || (state == ST_DATA && bitCnt < CNT_W'(BITS_PER_BYTE)));
    strobes.cmpEn   = (state == ST_CMP) && !busEdge;
    strobes.idWrEn  = hostWrEn && (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      ackDrive   <= 1'b0;
      matchValid <= 1'b0;
      byteRecvd  <= 1'b0;
      hostWrErr  <= 1'b0;
    end else begin
      matchValid <= 1'b0;
      byteRecvd  <= 1'b0;
      hostWrErr  <= hostWrEn && (state != ST_IDLE);
      if (events.stopDet) begin
        state    <= ST_IDLE;
        ackDrive <= 1'b0;
      end else if (events.startDet) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (events.sclRise) begin
              if (bitCnt == CNT_W'(BITS_PER_BYTE - 1)) state <= ST_CMP;
              else bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_CMP: begin
            matchValid <= anyHit;
            state      <= anyHit ? ST_ACK_WAIT : ST_DORMANT;
          end
          ST_ACK_WAIT: begin
            if (events.sclFall) begin
              ackDrive <= 1'b1;
              state    <= ST_ACK_HOLD;
            end
          end
          ST_ACK_HOLD: begin
            if (events.sclFall) begin
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              state    <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (events.sclRise) begin
              if (bitCnt == CNT_W'(BITS_PER_BYTE - 1)) byteRecvd <= 1'b1;
              bitCnt <= (bitCnt == CNT_W'(BITS_PER_BYTE)) ? '0 : bitCnt + 1'b1;
            end
          end
          ST_IDLE, ST_DORMANT: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sdaPullLow = ackDrive;
  assign busBusy    = (state != ST_IDLE);

  // R6: acknowledge drive only changes while the clock line is low
  assert_ack_edge_scl_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(ackDrive) && !$past(busEdge)) |-> !events.sclLevel);

  // R11: a stop returns the block to the free state
  assert_stop_to_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    events.stopDet |=> (!busBusy && !sdaPullLow));

  // R2: a start always begins a new address phase
  assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    events.startDet |=> (state == ST_ADDR && bitCnt == '0));

  // R7: a dormant block stays silent
  assert_dormant_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DORMANT) |-> (!sdaPullLow && !matchValid && !byteRecvd));

endmodule

// File: rtl/i2c_multi_id_matcher.sv
module i2c_multi_id_matcher
  import i2c_match_pkg::*;
#(
  parameter int NUM_IDS = 4,
  parameter int ID_W    = 8,
  localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  input  logic             hostWrEn,
  input  logic [IDX_W-1:0] hostWrSel,
  input  logic [ID_W-1:0]  hostWrData,
  output logic             hostWrErr,
  output logic             busBusy,
  output logic             matchValid,
  output logic [IDX_W-1:0] matchIdx,
  output logic             matchDir,
  output logic             byteRecvd,
  output logic [ID_W-1:0]  rxByte
);

  busEvents_t  events;
  ctlStrobes_t strobes;
  logic        anyHit;

  i2c_match_datapath #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .strobes    (strobes),
    .busyLevel  (busBusy),
    .hostWrSel  (hostWrSel),
    .hostWrData (hostWrData),
    .events     (events),
    .anyHit     (anyHit),
    .matchIdx   (matchIdx),
    .matchDir   (matchDir),
    .rxByte     (rxByte)
  );

  i2c_match_control uControl (
    .clk        (clk),
    .rstN       (rstN),
    .events     (events),
    .anyHit     (anyHit),
    .hostWrEn   (hostWrEn),
    .strobes    (strobes),
    .sdaPullLow (sdaPullLow),
    .hostWrErr  (hostWrErr),
    .busBusy    (busBusy),
    .matchValid (matchValid),
    .byteRecvd  (byteRecvd)
  );

endmodule

// File: tb/tb_i2c_multi_id_matcher.sv
`timescale 1ns/1ps
module tb_i2c_multi_id_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = 6;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaPullLow, hostWrEn, hostWrErr, busBusy, matchValid, matchDir, byteRecvd;
  logic [1:0] hostWrSel, matchIdx;
  logic [7:0] hostWrData, rxByte;
  logic sdaLine;

  int errors = 0, checks = 0;
  int matchCnt = 0, byteCnt = 0, errCnt = 0;
  logic [1:0] lastIdx;
  logic lastDir;
  logic [7:0] lastByte;
  bit done = 0;

  assign sdaLine = sdaM & ~sdaPullLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_multi_id_matcher dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .hostWrEn(hostWrEn), .hostWrSel(hostWrSel), .hostWrData(hostWrData),
    .hostWrErr(hostWrErr), .busBusy(busBusy), .matchValid(matchValid),
    .matchIdx(matchIdx), .matchDir(matchDir), .byteRecvd(byteRecvd), .rxByte(rxByte)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (matchValid) begin matchCnt++; lastIdx = matchIdx; lastDir = matchDir; end
      if (byteRecvd) begin byteCnt++; lastByte = rxByte; end
      if (hostWrErr) errCnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(QTR);
    sclM = 1'b1; waitClk(QTR);
    sdaM = 1'b0; waitClk(QTR);
    sclM = 1'b0; waitClk(QTR);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(QTR);
    sclM = 1'b1; waitClk(QTR);
    sdaM = 1'b1; waitClk(2*QTR);
  endtask

  task automatic sendBit(input logic b, output logic seen);
    sdaM = b;    waitClk(QTR);
    sclM = 1'b1; waitClk(QTR);
    seen = sdaLine;
    waitClk(QTR);
    sclM = 1'b0; waitClk(QTR);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(v[i], s);
    sendBit(1'b1, s);
    ack = !s;
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] val);
    hostWrSel = sel; hostWrData = val; hostWrEn = 1'b1;
    waitClk(1);
    hostWrEn = 1'b0;
    waitClk(3);
  endtask

  task automatic testReset();
    chk("R1 busBusy", busBusy, 0);
    chk("R1 sdaPullLow", sdaPullLow, 0);
    chk("R1 pulses", matchValid | byteRecvd | hostWrErr, 0);
    // registers reset to 0x00: address 0x01 matches index 0
    busStart();
    chk("R2 busBusy after start", busBusy, 1);
    begin
      logic ack;
      sendByte(8'h01, ack);
      chk("R1 reset id match", matchCnt, 1);
      chk("R1 reset id ack", ack, 1);
      chk("R1 reset idx", lastIdx, 0);
    end
    busStop();
    chk("R11 busBusy after stop", busBusy, 0);
    chk("R11 released", sdaPullLow, 0);
  endtask

  task automatic testProgram();
    int e0 = errCnt;
    hostWrite(2'd0, 8'hA0);
    hostWrite(2'd1, 8'h52);
    hostWrite(2'd2, 8'h53);
    hostWrite(2'd3, 8'h3C);
    chk("R8 no error on idle write", errCnt - e0, 0);
  endtask

  task automatic testMatchRead();
    logic ack;
    int m0 = matchCnt;
    busStart();
    sendByte(8'h3D, ack);
    chk("R6 ack on match", ack, 1);
    chk("R3 match count", matchCnt - m0, 1);
    chk("R5 idx for id3", lastIdx, 3);
    chk("R4 dir read", lastDir, 1);
    busStop();
  endtask

  task automatic testPriority();
    logic ack;
    int m0 = matchCnt;
    busStart();
    sendByte(8'h52, ack);
    chk("R3 ack", ack, 1);
    chk("R5 lowest of ids 1 and 2", lastIdx, 1);
    chk("R4 dir write", lastDir, 0);
    chk("R5 single pulse", matchCnt - m0, 1);
    busStop();
  endtask

  task automatic testNoMatchRestart();
    logic ack;
    int m0 = matchCnt, b0 = byteCnt;
    busStart();
    sendByte(8'h10, ack);
    chk("R7 no ack", ack, 0);
    chk("R7 no match pulse", matchCnt - m0, 0);
    sendByte(8'h00, ack);
    chk("R7 dormant no ack", ack, 0);
    chk("R7 dormant no byte strobe", byteCnt - b0, 0);
    busStart();
    sendByte(8'hA1, ack);
    chk("R7 repeated start ack", ack, 1);
    chk("R7 repeated start idx", lastIdx, 0);
    chk("R4 dir after restart", lastDir, 1);
    busStop();
  endtask

  task automatic testDataAndBusyWrite();
    logic ack;
    int b0 = byteCnt, e0 = errCnt, m0;
    busStart();
    sendByte(8'hA0, ack);
    chk("R6 ack address", ack, 1);
    sendByte(8'h5A, ack);
    chk("R10 first byte strobe", byteCnt - b0, 1);
    chk("R10 first byte value", lastByte, 8'h5A);
    hostWrite(2'd0, 8'h77);
    chk("R9 error pulse", errCnt - e0, 1);
    sendByte(8'hC3, ack);
    chk("R10 second byte strobe", byteCnt - b0, 2);
    chk("R10 second byte value", lastByte, 8'hC3);
    busStop();
    m0 = matchCnt;
    busStart();
    sendByte(8'hA0, ack);
    chk("R9 old id kept", ack, 1);
    chk("R9 old id idx", lastIdx, 0);
    busStop();
    busStart();
    sendByte(8'h76, ack);
    chk("R9 new id not taken", ack, 0);
    chk("R9 match total", matchCnt - m0, 1);
    busStop();
  endtask

  task automatic testIdleRewrite();
    logic ack;
    int e0 = errCnt;
    hostWrite(2'd0, 8'h77);
    chk("R8 idle write no error", errCnt - e0, 0);
    busStart();
    sendByte(8'h76, ack);
    chk("R8 new id acks", ack, 1);
    chk("R8 new id idx", lastIdx, 0);
    chk("R4 dir write", lastDir, 0);
    busStop();
  endtask

  initial begin
    hostWrEn = 1'b0; hostWrSel = '0; hostWrData = '0;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    testReset();
    testProgram();
    testMatchRead();
    testPriority();
    testNoMatchRestart();
    testDataAndBusyWrite();
    testIdleRewrite();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule